// File: doc/BRIEF.md
# Configurable Binary Correlation Array

The block compares a stream of input samples against a stored pattern of one bit per tap and reports how well they agree. It holds 256 taps, built as eight stages of 32 taps each. With 1-bit samples the stages form one long 256-tap window. With 2-, 4- or 8-bit samples they are split into equal groups, and each group serves one bit plane of the sample, giving windows of 128, 64 or 32 taps. Each tap carries a mask bit that removes it from the score.

The pattern and the mask are first shifted into shadow (preload) copies through their own buses and load strobes. An active-low transfer strobe then copies both shadows into the working copies on a clock edge. New patterns can therefore be staged while scoring goes on without a gap. The block puts out the raw agreement count of every bit plane and a score in which the count of plane k carries weight 2^k. The score is clipped at the 9-bit maximum.

Top module: `bcorr_array`

## Requirements
- R1: While rst_ni is low, every register is cleared. score_o and plane_cnt_o read 0.
- R2: A tap agrees when its sample bit equals its working pattern bit. In 1-bit mode (prec_i = 0) the score is the number of unmasked agreeing taps, from 0 to 256.
- R3: A working mask bit of 1 removes its tap from every count. When all 256 mask bits are 1, every count and the score read 0.
- R4: prec_i selects 1, 2, 4 or 8 planes (encodings 0..3). Each group of G = 8 >> prec_i consecutive stages forms one plane. Stage s (0 = first) belongs to plane (7 - s) / G. The first stage of each group shifts in din_i[plane], and the other stages continue from the last tap of the stage before them.
- R5: score_o is the sum over planes of count_k * 2^k. It saturates at 511.
- R6: Each cycle with ref_ld_i high shifts the pattern shadow by one tap. The first stage of each group takes ref_i[7 - s / G]. So in 1-bit mode only ref_i[7] is used, and in 8-bit mode ref_i[7] feeds stage 0 and ref_i[0] feeds stage 7.
- R7: The mask shadow is filled from msk_i under msk_ld_i, in the same order as R6.
- R8: On a clock edge with xfer_ni low, the working pattern and working mask take the shadow values held before that edge. With xfer_ni high they hold, so shadow loads do not change the score.
- R9: Changing prec_i does not alter the stored pattern or mask. Only the grouping of stages changes.
- R10: Samples on din_i are taken on the rising edge. Their effect appears on score_o and plane_cnt_o one edge later.
- R11: plane_cnt_o holds the count of plane k in bits [9k+8 : 9k]. Planes at or above 2^prec_i read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prec_i | input | 2 | Sample precision: 0=1 bit, 1=2, 2=4, 3=8 bits |
| din_i | input | 8 | Sample bits, bit k = plane k |
| ref_i | input | 8 | Pattern load bus |
| ref_ld_i | input | 1 | Shift ref_i into the pattern shadow |
| msk_i | input | 8 | Mask load bus |
| msk_ld_i | input | 1 | Shift msk_i into the mask shadow |
| xfer_ni | input | 1 | Copy shadows to working copies, active low |
| plane_cnt_o | output | 72 | Per-plane agreement counts, 9 bits each |
| score_o | output | 9 | Weighted, saturated score |

## Verification
Random 1-bit streams against a random pattern and a sparse random mask test the agreement count and the mask gating tap by tap. A fully masked window and an all-agreeing 8-bit window test the two extremes: zero, and clipping at 511. Random streams in each of the 2-, 4- and 8-bit groupings, plus a precision switch with no reload, separate a wrong plane assignment, a wrong weight or a disturbed pattern from correct behaviour. Loading with the transfer strobe held off, and a single 1 sent through a zero stream, expose early transfers and latency off by one cycle.

// File: rtl/bcorr_pkg.sv
package bcorr_pkg;

  // stages per bit-plane group
  function automatic int grp_len(int n_stg, int prec);
    return n_stg >> prec;
  endfunction

  // bit plane served by stage s (first stages take the top plane)
  function automatic int plane_of(int s, int n_stg, int prec);
    return (n_stg - 1 - s) / grp_len(n_stg, prec);
  endfunction

  function automatic logic is_head(int s, int n_stg, int prec);
    return (s % grp_len(n_stg, prec)) == 0;
  endfunction

  // load-bus bit feeding the head of stage s's group
  function automatic int load_src(int s, int n_stg, int prec);
    return n_stg - 1 - s / grp_len(n_stg, prec);
  endfunction

endpackage

// File: rtl/bcorr_shift_chain.sv
module bcorr_shift_chain #(
  parameter int unsigned N_STAGES   = 8,
  parameter int unsigned STAGE_TAPS = 32,
  localparam int unsigned TOTAL     = N_STAGES * STAGE_TAPS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [N_STAGES-1:0] head_sel_i,
  input  logic [N_STAGES-1:0] head_bit_i,
  output logic [TOTAL-1:0]    q_o
);

  logic [TOTAL-1:0] q_q;

  for (genvar s = 0; s < N_STAGES; s++) begin : g_stg
    logic feed;
    if (s == 0) begin : g_first
      assign feed = head_bit_i[0];
    end else begin : g_rest
      assign feed = head_sel_i[s] ? head_bit_i[s] : q_q[s*STAGE_TAPS-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q_q[s*STAGE_TAPS +: STAGE_TAPS] <= '0;
      end else if (en_i) begin
        q_q[s*STAGE_TAPS +: STAGE_TAPS] <=
          {q_q[s*STAGE_TAPS +: STAGE_TAPS-1], feed};
      end
    end
  end

  assign q_o = q_q;

  p_head_in_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> q_o[0] == $past(head_bit_i[0]));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));

endmodule

// File: rtl/bcorr_stage_count.sv
module bcorr_stage_count #(
  parameter int unsigned STAGE_TAPS = 32,
  localparam int unsigned CNT_W     = $clog2(STAGE_TAPS + 1)
) (
  input  logic [STAGE_TAPS-1:0] data_i,
  input  logic [STAGE_TAPS-1:0] patt_i,
  input  logic [STAGE_TAPS-1:0] mask_i,
  output logic [CNT_W-1:0]      cnt_o
);

  logic [STAGE_TAPS-1:0] hit;

  assign hit = ~(data_i ^ patt_i) & ~mask_i;

  always_comb begin
    cnt_o = '0;
    for (int j = 0; j < STAGE_TAPS; j++) begin
      cnt_o = cnt_o + CNT_W'(hit[j]);
    end
  end

endmodule

// File: rtl/bcorr_combine.sv
module bcorr_combine
  import bcorr_pkg::*;
#(
  parameter int unsigned N_STAGES   = 8,
  parameter int unsigned STAGE_TAPS = 32,
  parameter int unsigned SCORE_W    = 9,
  localparam int unsigned SC_W      = $clog2(STAGE_TAPS + 1),
  localparam int unsigned CNT_W     = $clog2(N_STAGES * STAGE_TAPS + 1),
  localparam int unsigned PREC_W    = $clog2($clog2(N_STAGES) + 1),
  localparam int unsigned ACC_W     = CNT_W + N_STAGES,
  localparam int unsigned SCORE_MAX = (1 << SCORE_W) - 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [PREC_W-1:0]         prec_i,
  input  logic [N_STAGES*SC_W-1:0]  stg_cnt_i,
  output logic [N_STAGES*CNT_W-1:0] plane_cnt_o,
  output logic [SCORE_W-1:0]        score_o
);

  logic [N_STAGES*CNT_W-1:0] plane_d, plane_q;
  logic [ACC_W-1:0]          acc;
  logic [SCORE_W-1:0]        score_d, score_q;

  always_comb begin
    plane_d = '0;
    for (int k = 0; k < N_STAGES; k++) begin
      for (int s = 0; s < N_STAGES; s++) begin
        if (plane_of(s, N_STAGES, int'(prec_i)) == k) begin
          plane_d[k*CNT_W +: CNT_W] = plane_d[k*CNT_W +: CNT_W]
                                    + CNT_W'(stg_cnt_i[s*SC_W +: SC_W]);
        end
      end
    end
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < N_STAGES; k++) begin
      acc = acc + (ACC_W'(plane_d[k*CNT_W +: CNT_W]) << k);
    end
    score_d = (acc > ACC_W'(SCORE_MAX)) ? SCORE_W'(SCORE_MAX) : acc[SCORE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      plane_q <= '0;
      score_q <= '0;
    end else begin
      plane_q <= plane_d;
      score_q <= score_d;
    end
  end

  assign plane_cnt_o = plane_q;
  assign score_o     = score_q;

  p_unused_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prec_i == '0 |=> plane_cnt_o[N_STAGES*CNT_W-1:CNT_W] == '0);

  p_single_plane_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prec_i == '0 |=> ACC_W'(score_o) == ACC_W'(plane_cnt_o[CNT_W-1:0]));

endmodule

// File: rtl/bcorr_array.sv
module bcorr_array
  import bcorr_pkg::*;
#(
  parameter int unsigned N_STAGES   = 8,
  parameter int unsigned STAGE_TAPS = 32,
  parameter int unsigned SCORE_W    = 9,
  localparam int unsigned TOTAL     = N_STAGES * STAGE_TAPS,
  localparam int unsigned SC_W      = $clog2(STAGE_TAPS + 1),
  localparam int unsigned CNT_W     = $clog2(TOTAL + 1),
  localparam int unsigned PREC_W    = $clog2($clog2(N_STAGES) + 1),
  localparam int unsigned IDX_W     = $clog2(N_STAGES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [PREC_W-1:0]         prec_i,
  input  logic [N_STAGES-1:0]       din_i,
  input  logic [N_STAGES-1:0]       ref_i,
  input  logic                      ref_ld_i,
  input  logic [N_STAGES-1:0]       msk_i,
  input  logic                      msk_ld_i,
  input  logic                      xfer_ni,
  output logic [N_STAGES*CNT_W-1:0] plane_cnt_o,
  output logic [SCORE_W-1:0]        score_o
);

  logic [N_STAGES-1:0]      head_sel, din_head, ref_head, msk_head;
  logic [TOTAL-1:0]         data_taps, ref_pre, msk_pre;
  logic [TOTAL-1:0]         ref_act, msk_act;
  logic [N_STAGES*SC_W-1:0] stg_cnt;

  always_comb begin
    for (int s = 0; s < N_STAGES; s++) begin
      head_sel[s] = is_head(s, N_STAGES, int'(prec_i));
      din_head[s] = din_i[IDX_W'(plane_of(s, N_STAGES, int'(prec_i)))];
      ref_head[s] = ref_i[IDX_W'(load_src(s, N_STAGES, int'(prec_i)))];
      msk_head[s] = msk_i[IDX_W'(load_src(s, N_STAGES, int'(prec_i)))];
    end
  end

  bcorr_shift_chain #(.N_STAGES(N_STAGES), .STAGE_TAPS(STAGE_TAPS)) u_data (
    .clk_i, .rst_ni, .en_i(1'b1),
    .head_sel_i(head_sel), .head_bit_i(din_head), .q_o(data_taps));

  bcorr_shift_chain #(.N_STAGES(N_STAGES), .STAGE_TAPS(STAGE_TAPS)) u_ref_pre (
    .clk_i, .rst_ni, .en_i(ref_ld_i),
    .head_sel_i(head_sel), .head_bit_i(ref_head), .q_o(ref_pre));

  bcorr_shift_chain #(.N_STAGES(N_STAGES), .STAGE_TAPS(STAGE_TAPS)) u_msk_pre (
    .clk_i, .rst_ni, .en_i(msk_ld_i),
    .head_sel_i(head_sel), .head_bit_i(msk_head), .q_o(msk_pre));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_act <= '0;
      msk_act <= '0;
    end else if (!xfer_ni) begin
      ref_act <= ref_pre;
      msk_act <= msk_pre;
    end
  end

  for (genvar s = 0; s < N_STAGES; s++) begin : g_cnt
    bcorr_stage_count #(.STAGE_TAPS(STAGE_TAPS)) u_cnt (
      .data_i(data_taps[s*STAGE_TAPS +: STAGE_TAPS]),
      .patt_i(ref_act[s*STAGE_TAPS +: STAGE_TAPS]),
      .mask_i(msk_act[s*STAGE_TAPS +: STAGE_TAPS]),
      .cnt_o (stg_cnt[s*SC_W +: SC_W]));
  end

  bcorr_combine #(.N_STAGES(N_STAGES), .STAGE_TAPS(STAGE_TAPS), .SCORE_W(SCORE_W)) u_comb (
    .clk_i, .rst_ni, .prec_i, .stg_cnt_i(stg_cnt),
    .plane_cnt_o, .score_o);

  p_xfer_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_ni |=> $stable(ref_act) && $stable(msk_act));

  p_xfer_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_ni |=> ref_act == $past(ref_pre) && msk_act == $past(msk_pre));

  p_full_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&msk_act) |=> score_o == '0 && plane_cnt_o == '0);

  p_prec_keeps_ref_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_ld_i && !msk_ld_i |=> $stable(ref_pre) && $stable(msk_pre));

endmodule

// File: tb/bcorr_array_tb.sv
module bcorr_array_tb_top;

  localparam int N = 8;
  localparam int T = 32;
  localparam int TOT = N * T;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  prec = '0;
  logic [7:0]  din = '0, refb = '0, mskb = '0;
  logic        ref_ld = 1'b0, msk_ld = 1'b0, xfer_n = 1'b1;
  logic [71:0] plane_cnt;
  logic [8:0]  score;

  int total = 0, bad = 0, cycles = 0;

  bit m_dat[TOT], m_rp[TOT], m_ra[TOT], m_mp[TOT], m_ma[TOT];
  int m_plane[N];
  int m_score = 0;

  always #10 clk = ~clk;

  bcorr_array dut_i (
    .clk_i(clk), .rst_ni(rst_n), .prec_i(prec), .din_i(din),
    .ref_i(refb), .ref_ld_i(ref_ld), .msk_i(mskb), .msk_ld_i(msk_ld),
    .xfer_ni(xfer_n), .plane_cnt_o(plane_cnt), .score_o(score));

  task automatic final_report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      final_report();
    end
  end

  function automatic bit head(int i, int g);
    return (i % T == 0) && ((i / T) % g == 0);
  endfunction

  // represents the next rising edge, using the inputs now driven
  task automatic model_tick();
    int g = N >> prec;
    bit nd[TOT], nrp[TOT], nmp[TOT];
    int acc = 0;
    for (int k = 0; k < N; k++) m_plane[k] = 0;
    for (int i = 0; i < TOT; i++) begin
      if (!m_ma[i] && m_dat[i] == m_ra[i]) m_plane[(N - 1 - i / T) / g]++;
    end
    for (int k = 0; k < N; k++) acc += m_plane[k] << k;
    m_score = (acc > 511) ? 511 : acc;
    for (int i = 0; i < TOT; i++) begin
      int s = i / T;
      nd[i]  = head(i, g) ? din[(N - 1 - s) / g]   : m_dat[(i > 0) ? i - 1 : 0];
      nrp[i] = head(i, g) ? refb[N - 1 - s / g]    : m_rp[(i > 0) ? i - 1 : 0];
      nmp[i] = head(i, g) ? mskb[N - 1 - s / g]    : m_mp[(i > 0) ? i - 1 : 0];
    end
    if (!xfer_n) begin
      m_ra = m_rp;
      m_ma = m_mp;
    end
    m_dat = nd;
    if (ref_ld) m_rp = nrp;
    if (msk_ld) m_mp = nmp;
  endtask

  task automatic compare(string tag);
    total++;
    if (int'(score) != m_score) begin
      bad++;
      $display("FAIL %s score actual=%0d expected=%0d", tag, score, m_score);
    end
    for (int k = 0; k < N; k++) begin
      total++;
      if (int'(plane_cnt[k*9 +: 9]) != m_plane[k]) begin
        bad++;
        $display("FAIL %s plane%0d actual=%0d expected=%0d", tag, k,
                 plane_cnt[k*9 +: 9], m_plane[k]);
      end
    end
  endtask

  task automatic step(string tag);
    model_tick();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic run_random(string tag, int n);
    for (int c = 0; c < n; c++) begin
      din = 8'($urandom);
      step(tag);
    end
  endtask

  task automatic fill_mask(bit ones, int n, string tag);
    msk_ld = 1'b1;
    for (int c = 0; c < n; c++) begin
      mskb = ones ? 8'hFF : 8'h00;
      din = 8'($urandom);
      step(tag);
    end
    msk_ld = 1'b0;
  endtask

  task automatic do_xfer(string tag);
    xfer_n = 1'b0;
    step(tag);
    xfer_n = 1'b1;
  endtask

  initial begin
    for (int k = 0; k < N; k++) m_plane[k] = 0;
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      compare("R1");
    end
    rst_n = 1'b1;

    // R6: 1-bit mode pattern fill through bit 7 only, other bits noise
    ref_ld = 1'b1;
    for (int c = 0; c < TOT; c++) begin
      refb = 8'($urandom);
      din  = 8'($urandom);
      step("R6");
    end
    ref_ld = 1'b0;

    // R7: sparse random mask
    msk_ld = 1'b1;
    for (int c = 0; c < TOT; c++) begin
      mskb = (($urandom % 4) == 0) ? 8'h80 : 8'h00;
      mskb[6:0] = 7'($urandom);
      din = 8'($urandom);
      step("R7");
    end
    msk_ld = 1'b0;

    do_xfer("R8");
    run_random("R2", 300);
    run_random("R10", 20);

    // R8: shadow loads with transfer held off leave score alone
    ref_ld = 1'b1;
    for (int c = 0; c < 60; c++) begin
      refb = 8'($urandom);
      din  = 8'($urandom);
      step("R8");
    end
    ref_ld = 1'b0;

    // R3: fully masked window
    fill_mask(1'b1, TOT, "R7");
    do_xfer("R3");
    run_random("R3", 40);
    total++;
    if (score != 0) begin
      bad++;
      $display("FAIL R3 score actual=%0d expected=0", score);
    end
    fill_mask(1'b0, TOT, "R7");
    do_xfer("R8");

    // R4/R5/R11: multi-bit groupings
    prec = 2'd1; run_random("R4", 200);
    prec = 2'd2; run_random("R5", 200);
    prec = 2'd3; run_random("R11", 200);

    // R6: parallel fill in 8-bit mode
    ref_ld = 1'b1;
    for (int c = 0; c < T; c++) begin
      refb = 8'($urandom);
      din  = 8'($urandom);
      step("R6");
    end
    ref_ld = 1'b0;
    do_xfer("R8");
    run_random("R4", 100);

    // R9: regroup without reload
    prec = 2'd0; run_random("R9", 300);
    prec = 2'd2; run_random("R9", 100);

    // R5: saturation, all-zero pattern in 8-bit mode with all-zero samples
    prec = 2'd3;
    ref_ld = 1'b1; refb = 8'h00;
    for (int c = 0; c < T; c++) begin
      din = 8'($urandom);
      step("R6");
    end
    ref_ld = 1'b0;
    do_xfer("R8");
    din = 8'h00;
    for (int c = 0; c < T + 2; c++) step("R5");
    total++;
    if (score != 9'd511) begin
      bad++;
      $display("FAIL R5 saturate actual=%0d expected=511", score);
    end

    // R10: one-cycle pulse through a zero stream in 1-bit mode
    prec = 2'd0;
    for (int c = 0; c < TOT + 2; c++) step("R10");
    total++;
    if (score != 9'd256) begin
      bad++;
      $display("FAIL R2 full agree actual=%0d expected=256", score);
    end
    din = 8'h01;
    step("R10");
    din = 8'h00;
    total++;
    if (score != 9'd256) begin
      bad++;
      $display("FAIL R10 early actual=%0d expected=256", score);
    end
    step("R10");
    total++;
    if (score != 9'd255) begin
      bad++;
      $display("FAIL R10 pulse actual=%0d expected=255", score);
    end
    run_random("R10", 10);

    final_report();
  end

endmodule